// File: doc/BRIEF.md
# Multichannel PCM Sample FIFO Router

This block connects a 32-bit register data port to a serial audio shifter. It holds up to three channel-pair FIFOs: front, surround, and center/LFE. A channel mode selects whether one, two or three of them are active. In the transmit direction, software writes words into the data port. A rotating write pointer spreads the words across the active pairs. On each shifter request the block hands over one complete side: every left sample of a sample time together, then every right sample. In the receive direction, the shifter delivers one side at a time. The block stores the samples, and register reads drain them in the same rotation.

Samples are either up to 24 bits wide, one to a word and right-justified, or 16 bits wide and packed two to a word. The block defines what happens when a FIFO is full, when it is empty, and when only the left channel is in use (mono). It also drives a busy flag that follows the serial activity. The shifter itself is reduced to a request/acknowledge port in transmit and a valid strobe in receive.

Top module: `pcm_fifo_router`

## Requirements
- R1: `cfgChanMode` selects the active pairs: 0 selects front only, 1 selects front and surround, 2 selects all three, and 3 behaves as 0. In `shTxData`, bits [23:0] carry front, [47:24] carry surround and [71:48] carry center/LFE. Inactive lanes read zero.
- R2: In 24-bit stereo, successive data-port words go to the left of each active pair in the order front, surround, center. The right of each pair follows in the same order. For example, in six-channel mode the order is LF, LS, C, RF, RS, LFE. Only bits [23:0] of a word are carried.
- R3: With `cfgHalfWord` set, one word holds one pair for one sample time: the left sample in bits [15:0] and the right sample in bits [31:16]. Words rotate over the active pairs, and a sample is zero-extended to 24 bits on its lane.
- R4: Each FIFO holds 8 words. A write to a full FIFO is dropped, the stored words are unchanged, and the rotation still advances.
- R5: A read of an empty FIFO returns zero. While transmit is selected, reads return zero and remove nothing.
- R6: A left side is taken from the FIFOs only when every active FIFO holds a whole sample time: at least 2 words in 24-bit stereo, or at least 1 word otherwise. Otherwise that set goes out as zeros. A right side comes from the FIFOs exactly when its left side did.
- R7: `shAck` rises one cycle after a serviced `shReq`, with the side's samples on `shTxData`. `shRight` is 0 for the first side after start, and the sides then alternate. No acknowledge is given in receive.
- R8: Mono: the right side is sent as zeros and consumes nothing on transmit, and is discarded on receive. In 16-bit mono the left sample sits in bits [15:0] of a word.
- R9: Receive stores each side in interleave order, so reads return the left of each active pair and then the right of each. In 24-bit mode each word is zero-extended. In 16-bit stereo the two sides of a pair combine into one word {right, left}.
- R10: `busy` is set in transmit when a left side is first taken from the FIFOs, and in receive in the cycle after `run` is seen high. It clears only after `run` is low and the pending right side, if any, is done.
- R11: Mode, sample size, mono and direction are captured only while `run` is low and no side is pending. Changes made during a run take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Starts and stops serial operation |
| cfgChanMode | input | 2 | Channel mode (R1) |
| cfgHalfWord | input | 1 | 16-bit packed samples |
| cfgMono | input | 1 | Left channel only |
| cfgRxDir | input | 1 | 1 = receive, 0 = transmit |
| regWrEn | input | 1 | Data-port write strobe |
| regWrData | input | 32 | Data-port write word |
| regRdEn | input | 1 | Data-port read strobe (pops) |
| regRdData | output | 32 | Word at the read position, zero if empty |
| shReq | input | 1 | Shifter asks for the next side |
| shAck | output | 1 | Side samples valid on shTxData |
| shRight | output | 1 | The acknowledged side is right |
| shTxData | output | 72 | Three 24-bit transmit lanes |
| shRxValid | input | 1 | Shifter delivers a received side |
| shRxData | input | 72 | Three 24-bit receive lanes |
| busy | output | 1 | Serial activity flag |

## Verification
The hardest situation to reach is a busy flag held high while `run` is already low with a right side still owed, because it needs the run stop to fall between the two halves of one sample time. The bench takes a left side, drops `run` before asking for the right side, and watches `busy` before and after that last request. Partial FIFO fill is also reached on purpose: a single word written in 24-bit stereo must still give zeros. Full-FIFO drops are reached by writing ten words before start and draining eight.

// File: rtl/pcm_router_pkg.sv
package pcm_router_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int LANE_W    = $clog2(NUM_PAIRS);

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic [NUM_PAIRS-1:0] push;
    logic [NUM_PAIRS-1:0] pop;
    logic [NUM_PAIRS-1:0] laneMask;
    logic                 pushFromReg;
    logic                 rxPackRight;
    logic                 rxStageLeft;
    logic                 txLoad;
    logic                 txRight;
    logic                 txFromFifo;
    logic                 halfMode;
    logic                 readEnable;
    logic [LANE_W-1:0]    rdLane;
  } strobe_t;
endpackage

// File: rtl/pcm_pair_fifo.sv
module pcm_pair_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPush = push && (count != CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end
endmodule

// File: rtl/pcm_router_ctrl.sv
module pcm_router_ctrl
  import pcm_router_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            run,
  input  logic [1:0]                      cfgChanMode,
  input  logic                            cfgHalfWord,
  input  logic                            cfgMono,
  input  logic                            cfgRxDir,
  input  logic                            regWrEn,
  input  logic                            regRdEn,
  input  logic                            shReq,
  input  logic                            shRxValid,
  input  logic [NUM_PAIRS-1:0][CNT_W-1:0] laneCount,
  output strobe_t                         strb,
  output logic                            monoMode,
  output logic                            busy
);
  localparam int POS_W = $clog2(2 * NUM_PAIRS);

  logic [1:0]       modeQ;
  logic             halfQ, monoQ, rxQ;
  logic [POS_W-1:0] wrPos, rdPos, nPairs, seqLen, wrLane, rdLane;
  logic             rightNext, fromFifo;
  logic [NUM_PAIRS-1:0] laneMask, enough;
  logic [CNT_W-1:0] need;
  logic idle, active, cfgChanged, avail;
  logic wrStep, rdStep, txSvc, rxSvc, leftTake, rightNextN, busyNext;

  always_comb begin
    case (modeQ)
      2'd1:    nPairs = POS_W'(2);
      2'd2:    nPairs = POS_W'(3);
      default: nPairs = POS_W'(1);
    endcase
    seqLen = (halfQ || monoQ) ? nPairs : POS_W'(nPairs << 1);
    wrLane = (wrPos >= nPairs) ? wrPos - nPairs : wrPos;
    rdLane = (rdPos >= nPairs) ? rdPos - nPairs : rdPos;
    need   = (halfQ || monoQ) ? CNT_W'(1) : CNT_W'(2);
    for (int i = 0; i < NUM_PAIRS; i++) begin
      laneMask[i] = POS_W'(i) < nPairs;
      enough[i]   = laneCount[i] >= need;
    end
  end

  function automatic logic [POS_W-1:0] stepPos(input logic [POS_W-1:0] p,
                                               input logic [POS_W-1:0] len);
    return (p == len - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign idle       = !run && !rightNext;
  assign active     = !idle;
  assign cfgChanged = {cfgChanMode, cfgHalfWord, cfgMono, cfgRxDir} != {modeQ, halfQ, monoQ, rxQ};
  assign avail      = &(enough | ~laneMask);
  assign wrStep     = regWrEn && !rxQ;
  assign rdStep     = regRdEn && rxQ;
  assign txSvc      = shReq && active && !rxQ;
  assign rxSvc      = shRxValid && active && rxQ;
  assign leftTake   = txSvc && !rightNext && avail;
  assign rightNextN = (txSvc || rxSvc) ? !rightNext : rightNext;
  assign busyNext   = rxQ ? (run || rightNextN)
                          : ((busy || leftTake) && (run || rightNextN));
  assign monoMode   = monoQ;

  always_comb begin
    strb             = '0;
    strb.laneMask    = laneMask;
    strb.halfMode    = halfQ;
    strb.readEnable  = rxQ;
    strb.rdLane      = rdLane[LANE_W-1:0];
    strb.pushFromReg = wrStep;
    if (wrStep) strb.push[wrLane[LANE_W-1:0]] = 1'b1;
    if (rdStep) strb.pop[rdLane[LANE_W-1:0]]  = 1'b1;
    if (txSvc) begin
      strb.txLoad  = 1'b1;
      strb.txRight = rightNext;
      if (!rightNext) begin
        strb.txFromFifo = avail;
        if (avail && (!halfQ || monoQ)) strb.pop = strb.pop | laneMask;
      end else begin
        strb.txFromFifo = fromFifo && !monoQ;
        if (fromFifo && !monoQ) strb.pop = strb.pop | laneMask;
      end
    end
    if (rxSvc) begin
      if (!rightNext) begin
        if (halfQ && !monoQ) strb.rxStageLeft = 1'b1;
        else                 strb.push = strb.push | laneMask;
      end else if (!monoQ) begin
        strb.push        = strb.push | laneMask;
        strb.rxPackRight = halfQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= '0;
      halfQ     <= 1'b0;
      monoQ     <= 1'b0;
      rxQ       <= 1'b0;
      wrPos     <= '0;
      rdPos     <= '0;
      rightNext <= 1'b0;
      fromFifo  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (idle && cfgChanged) begin
        modeQ <= cfgChanMode;
        halfQ <= cfgHalfWord;
        monoQ <= cfgMono;
        rxQ   <= cfgRxDir;
        wrPos <= '0;
        rdPos <= '0;
      end else begin
        if (wrStep) wrPos <= stepPos(wrPos, seqLen);
        if (rdStep) rdPos <= stepPos(rdPos, seqLen);
      end
      rightNext <= rightNextN;
      if (txSvc && !rightNext) fromFifo <= avail;
      busy <= busyNext;
    end
  end
endmodule

// File: rtl/pcm_router_dp.sv
module pcm_router_dp
  import pcm_router_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  input  logic [WORD_W-1:0]               regWrData,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0]   shRxData,
  output logic [WORD_W-1:0]               regRdData,
  output logic [NUM_PAIRS*SAMPLE_W-1:0]   shTxData,
  output logic                            shAck,
  output logic                            shRight,
  output logic [NUM_PAIRS-1:0][CNT_W-1:0] laneCount
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] heads [NUM_PAIRS];

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_lane
    logic [SAMPLE_W-1:0] rxSample, txLane;
    logic [HALF_W-1:0]   stage;
    logic [WORD_W-1:0]   rxWord, pushWord;

    assign rxSample = shRxData[g*SAMPLE_W +: SAMPLE_W];

    always_comb begin
      if (strb.halfMode)
        rxWord = strb.rxPackRight ? {rxSample[HALF_W-1:0], stage}
                                  : {{HALF_W{1'b0}}, rxSample[HALF_W-1:0]};
      else
        rxWord = WORD_W'(rxSample);
      pushWord = strb.pushFromReg ? regWrData : rxWord;

      if (!strb.txFromFifo || !strb.laneMask[g])
        txLane = '0;
      else if (strb.halfMode)
        txLane = strb.txRight ? {{(SAMPLE_W-HALF_W){1'b0}}, heads[g][WORD_W-1:HALF_W]}
                              : {{(SAMPLE_W-HALF_W){1'b0}}, heads[g][HALF_W-1:0]};
      else
        txLane = heads[g][SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage <= '0;
        shTxData[g*SAMPLE_W +: SAMPLE_W] <= '0;
      end else begin
        if (strb.rxStageLeft) stage <= rxSample[HALF_W-1:0];
        if (strb.txLoad) shTxData[g*SAMPLE_W +: SAMPLE_W] <= txLane;
      end
    end

    pcm_pair_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (strb.push[g]),
      .pop   (strb.pop[g]),
      .wdata (pushWord),
      .head  (heads[g]),
      .count (laneCount[g])
    );
  end

  always_comb begin
    regRdData = '0;
    if (strb.readEnable && laneCount[strb.rdLane] != '0)
      regRdData = heads[strb.rdLane];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shAck   <= 1'b0;
      shRight <= 1'b0;
    end else begin
      shAck <= strb.txLoad;
      if (strb.txLoad) shRight <= strb.txRight;
    end
  end
endmodule

// File: rtl/pcm_fifo_router.sv
module pcm_fifo_router
  import pcm_router_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          run,
  input  logic [1:0]                    cfgChanMode,
  input  logic                          cfgHalfWord,
  input  logic                          cfgMono,
  input  logic                          cfgRxDir,
  input  logic                          regWrEn,
  input  logic [WORD_W-1:0]             regWrData,
  input  logic                          regRdEn,
  output logic [WORD_W-1:0]             regRdData,
  input  logic                          shReq,
  output logic                          shAck,
  output logic                          shRight,
  output logic [NUM_PAIRS*SAMPLE_W-1:0] shTxData,
  input  logic                          shRxValid,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0] shRxData,
  output logic                          busy
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t                         strb;
  logic                            monoMode;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] laneCount;

  pcm_router_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .run         (run),
    .cfgChanMode (cfgChanMode),
    .cfgHalfWord (cfgHalfWord),
    .cfgMono     (cfgMono),
    .cfgRxDir    (cfgRxDir),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .shReq       (shReq),
    .shRxValid   (shRxValid),
    .laneCount   (laneCount),
    .strb        (strb),
    .monoMode    (monoMode),
    .busy        (busy)
  );

  pcm_router_dp #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .shRxData  (shRxData),
    .regRdData (regRdData),
    .shTxData  (shTxData),
    .shAck     (shAck),
    .shRight   (shRight),
    .laneCount (laneCount)
  );
endmodule

// File: rtl/pcm_router_chk.sv
module pcm_router_chk
  import pcm_router_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            run,
  input logic                            busy,
  input logic                            shReq,
  input logic                            shAck,
  input logic                            shRight,
  input logic [NUM_PAIRS*SAMPLE_W-1:0]   shTxData,
  input logic                            regRdEn,
  input logic [WORD_W-1:0]               regRdData,
  input strobe_t                         strb,
  input logic                            monoMode,
  input logic [NUM_PAIRS-1:0][CNT_W-1:0] laneCount
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cnt
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
      laneCount[g] <= CNT_W'(DEPTH));
  end

  assert_ack_after_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    shAck |-> $past(shReq));

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && laneCount[strb.rdLane] == '0) |-> regRdData == '0);

  assert_mono_right_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (shAck && shRight && monoMode) |-> shTxData == '0);

  assert_idle_lane_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (shAck && !strb.laneMask[NUM_PAIRS-1]) |->
      shTxData[NUM_PAIRS*SAMPLE_W-1 -: SAMPLE_W] == '0);

  assert_busy_stop_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !$past(run));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(run) |-> ($stable(strb.laneMask) && $stable(strb.halfMode) &&
                    $stable(strb.readEnable) && $stable(monoMode)));
endmodule

bind pcm_fifo_router pcm_router_chk #(
  .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .run       (run),
  .busy      (busy),
  .shReq     (shReq),
  .shAck     (shAck),
  .shRight   (shRight),
  .shTxData  (shTxData),
  .regRdEn   (regRdEn),
  .regRdData (regRdData),
  .strb      (strb),
  .monoMode  (monoMode),
  .laneCount (laneCount)
);

// File: tb/sim_pcm_fifo_router.sv
module sim_pcm_fifo_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  cfgChanMode = '0;
  logic        cfgHalfWord = 1'b0, cfgMono = 1'b0, cfgRxDir = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, shReq = 1'b0, shRxValid = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        shAck, shRight, busy;
  logic [71:0] shTxData;
  logic [71:0] shRxData = '0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcm_fifo_router u0 (
    .clk(clk), .rstN(rstN), .run(run), .cfgChanMode(cfgChanMode),
    .cfgHalfWord(cfgHalfWord), .cfgMono(cfgMono), .cfgRxDir(cfgRxDir),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .shReq(shReq), .shAck(shAck), .shRight(shRight),
    .shTxData(shTxData), .shRxValid(shRxValid), .shRxData(shRxData), .busy(busy)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        half;
    logic        mono;
    logic [2:0]  nWords;
    logic [71:0] expL;
    logic [71:0] expR;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd2, 1'b0, 1'b0, 3'd6, {24'h112202, 24'h112201, 24'h112200}, {24'h112205, 24'h112204, 24'h112203}},
    '{2'd1, 1'b0, 1'b0, 3'd4, {24'h0, 24'h112201, 24'h112200}, {24'h0, 24'h112203, 24'h112202}},
    '{2'd0, 1'b0, 1'b0, 3'd2, {48'h0, 24'h112200}, {48'h0, 24'h112201}},
    '{2'd2, 1'b1, 1'b0, 3'd3, {24'h002202, 24'h002201, 24'h002200}, {24'h005511, 24'h005511, 24'h005511}},
    '{2'd1, 1'b1, 1'b0, 3'd2, {24'h0, 24'h002201, 24'h002200}, {24'h0, 24'h005511, 24'h005511}},
    '{2'd0, 1'b0, 1'b1, 3'd1, {48'h0, 24'h112200}, 72'h0},
    '{2'd0, 1'b1, 1'b1, 3'd1, {48'h0, 24'h002200}, 72'h0},
    '{2'd3, 1'b0, 1'b0, 3'd2, {48'h0, 24'h112200}, {48'h0, 24'h112201}}
  };

  function automatic logic [31:0] wordAt(input int i);
    return 32'h5511_2200 + i;
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] m, input logic h, input logic mo, input logic rx);
    @(negedge clk);
    cfgChanMode = m; cfgHalfWord = h; cfgMono = mo; cfgRxDir = rx;
    repeat (3) @(negedge clk);
  endtask

  task automatic writeWord(input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic readWord(output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic txSide();
    @(negedge clk); shReq = 1'b1;
    @(negedge clk); shReq = 1'b0; #1;
  endtask

  task automatic rxSide(input logic [71:0] d);
    @(negedge clk); shRxValid = 1'b1; shRxData = d;
    @(negedge clk); shRxValid = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk); run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R7 reset ack", {71'h0, shAck}, 72'h0);
    check("R10 reset busy", {71'h0, busy}, 72'h0);
    check("R5 reset read data", {40'h0, regRdData}, 72'h0);
    check("R1 reset lanes", shTxData, 72'h0);

    // vector table: transmit routing, packing, mono
    for (int v = 0; v < 8; v++) begin
      setCfg(VECS[v].mode, VECS[v].half, VECS[v].mono, 1'b0);
      for (int i = 0; i < int'(VECS[v].nWords); i++) writeWord(wordAt(i));
      @(negedge clk); run = 1'b1;
      txSide();
      check($sformatf("R2/R3/R8/R1 vec%0d left", v), shTxData, VECS[v].expL);
      check("R7 left flag", {70'h0, shAck, shRight}, 72'h2);
      check("R10 busy on first fifo set", {71'h0, busy}, 72'h1);
      txSide();
      check($sformatf("R2/R3/R8/R1 vec%0d right", v), shTxData, VECS[v].expR);
      check("R7 right flag", {70'h0, shAck, shRight}, 72'h3);
      stopRun();
      check("R10 busy clear", {71'h0, busy}, 72'h0);
    end

    // R6: empty and partial start gives zeros
    setCfg(2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); run = 1'b1;
    txSide();
    check("R6 empty left zero", shTxData, 72'h0);
    check("R10 busy stays low on zero set", {71'h0, busy}, 72'h0);
    txSide();
    writeWord(wordAt(0));
    txSide();
    check("R6 half set gives zero", shTxData, 72'h0);
    txSide();
    writeWord(wordAt(1));
    txSide();
    check("R6 full set taken", shTxData, {48'h0, 24'h112200});
    check("R10 busy set", {71'h0, busy}, 72'h1);
    txSide();
    check("R6 right follows left", shTxData, {48'h0, 24'h112201});
    stopRun();

    // R4: full FIFO drops extra words
    for (int i = 0; i < 10; i++) writeWord(wordAt(i));
    @(negedge clk); run = 1'b1;
    for (int s = 0; s < 4; s++) begin
      txSide();
      check("R4 stored left", shTxData, {48'h0, 24'h112200 + 24'(2*s)});
      txSide();
      check("R4 stored right", shTxData, {48'h0, 24'h112201 + 24'(2*s)});
    end
    txSide();
    check("R4 dropped words absent", shTxData, 72'h0);
    txSide();
    stopRun();

    // R9: six-channel receive order, R5 empty read, R7 no ack in receive
    setCfg(2'd2, 1'b0, 1'b0, 1'b1);
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    check("R10 rx busy with run", {71'h0, busy}, 72'h1);
    rxSide({24'hC0FFE2, 24'hC0FFE1, 24'hC0FFE0});
    rxSide({24'hBEEF02, 24'hBEEF01, 24'hBEEF00});
    txSide();
    check("R7 no ack in receive", {71'h0, shAck}, 72'h0);
    readWord(rd); check("R9 read LF", {40'h0, rd}, {40'h0, 32'h00C0FFE0});
    readWord(rd); check("R9 read LS", {40'h0, rd}, {40'h0, 32'h00C0FFE1});
    readWord(rd); check("R9 read C",  {40'h0, rd}, {40'h0, 32'h00C0FFE2});
    readWord(rd); check("R9 read RF", {40'h0, rd}, {40'h0, 32'h00BEEF00});
    readWord(rd); check("R9 read RS", {40'h0, rd}, {40'h0, 32'h00BEEF01});
    readWord(rd); check("R9 read LFE", {40'h0, rd}, {40'h0, 32'h00BEEF02});
    readWord(rd); check("R5 empty read zero", {40'h0, rd}, 72'h0);
    stopRun();
    check("R10 rx busy clear", {71'h0, busy}, 72'h0);

    // R9 with R3: 16-bit receive combines sides
    setCfg(2'd0, 1'b1, 1'b0, 1'b1);
    @(negedge clk); run = 1'b1;
    rxSide({48'h0, 24'h771234});
    rxSide({48'h0, 24'h88ABCD});
    readWord(rd); check("R9 R3 packed rx word", {40'h0, rd}, {40'h0, 32'hABCD1234});
    stopRun();

    // R8: mono receive drops right
    setCfg(2'd0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); run = 1'b1;
    rxSide({48'h0, 24'h123456});
    rxSide({48'h0, 24'h654321});
    readWord(rd); check("R8 mono rx left", {40'h0, rd}, {40'h0, 32'h00123456});
    readWord(rd); check("R8 mono rx right discarded", {40'h0, rd}, 72'h0);
    stopRun();

    // R11: config change while running, R10 busy across stop mid-set
    setCfg(2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); run = 1'b1;
    @(negedge clk); cfgChanMode = 2'd2; cfgHalfWord = 1'b1;
    writeWord(wordAt(0));
    writeWord(wordAt(1));
    readWord(rd); check("R5 tx-side read zero", {40'h0, rd}, 72'h0);
    txSide();
    check("R11 old mode kept", shTxData, {48'h0, 24'h112200});
    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 busy held while right pending", {71'h0, busy}, 72'h1);
    txSide();
    check("R11 old mode right", shTxData, {48'h0, 24'h112201});
    repeat (2) @(negedge clk);
    check("R10 busy clear after right", {71'h0, busy}, 72'h0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) writeWord(wordAt(i));
    @(negedge clk); run = 1'b1;
    txSide();
    check("R11 new mode at next start", shTxData, {24'h002202, 24'h002201, 24'h002200});
    txSide();
    stopRun();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule